// File: doc/BRIEF.md
# Station Address Shadow Memory

This block holds a 16-byte image that carries a network station address together with a few bytes used for bookkeeping. Bytes 0 to 5 are the six-byte station address and bytes 6 to 11 are reserved. Bytes 12 and 13 hold a 16-bit check value, and bytes 14 and 15 are expected to be 57h each. After reset an external serial-memory reader streams the image in one byte at a time. Until all sixteen bytes have arrived, the block reports itself busy and ignores the host.

Once it is loaded, a host reads the image and, when a configuration bit allows it, rewrites it. There are two access modes. The word mode allows byte reads and aligned 16-bit accesses. The doubleword mode allows only aligned 32-bit accesses. Host writes change only this on-chip copy and never go back to the serial memory. The block checks the check value against the other bytes at all times and shows the result on a flag. Any access whose size or alignment is illegal raises a one-cycle error.

Top module: `addr_shadow_mem`

## Requirements
- R1: After reset every byte of the image is 00h, `busy` is high, and `rd_data`, `access_err` and `checksum_ok` are all low.
- R2: While `busy` is high, each cycle with `ld_valid` high stores `ld_byte` at the next offset, in ascending order from 0 to 15. Idle cycles between bytes are allowed. `busy` is low from the cycle after the sixteenth byte is taken and stays low. Any `ld_valid` after that is ignored.
- R3: While `busy` is high, host strobes change nothing. The image stays as it is, and `access_err` and `rd_data` stay at zero.
- R4: `host_be` encodes the access size as 0001 for a byte, 0011 for a word and 1111 for a doubleword. `host_off` is the offset of the first byte. Data is little-endian: lane k (bits 8k+7:8k) carries byte `host_off`+k. The result of a read appears on `rd_data` in the cycle after the strobe, with unused lanes at zero. In every other cycle `rd_data` is zero.
- R5: In word mode (`dw_mode` = 0), a byte read is legal at any offset from 0h to Fh, and a word read is legal at any even offset.
- R6: In doubleword mode (`dw_mode` = 1), the only legal read is a doubleword at an offset whose two low bits are 00. Byte and word reads are illegal even at aligned offsets.
- R7: A write is legal only as a word at an even offset in word mode, or as a doubleword at an offset with its two low bits at 00 in doubleword mode. A legal, enabled write stores lane k of `host_wdata` at byte `host_off`+k.
- R8: When `wr_en_cfg` is low, a legal write leaves the image unchanged and raises no error.
- R9: An illegal access raises `access_err` for exactly the cycle after the strobe. Illegal means a wrong size or alignment for the mode, or read and write strobed in the same cycle. After an illegal access `rd_data` is zero and the image is unchanged.
- R10: `checksum_ok` is high exactly when `busy` is low and {byte 13, byte 12} equals the 16-bit unsigned sum of bytes 1 to 11, 14 and 15. It follows an image change in the same cycle as the change becomes visible, and byte 0 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load byte strobe |
| ld_byte | input | 8 | Load byte value |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_off | input | 4 | Offset of the first byte of the access |
| host_be | input | 4 | Access size mask, lanes from 0 upward |
| host_wdata | input | 32 | Write data, little-endian |
| dw_mode | input | 1 | 1 selects doubleword mode, 0 selects word mode |
| wr_en_cfg | input | 1 | Allows host writes to the image |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| access_err | output | 1 | One-cycle illegal-access flag |
| busy | output | 1 | High until the full image has been loaded |
| checksum_ok | output | 1 | Stored check value matches the recomputed sum |

## Verification
The bench builds the block with its default parameters: a 4-bit offset (16 bytes), a 32-bit data path, the check value at byte 12 and the combinational checksum variant. With these values every offset from 0h to Fh can be reached, including the top byte and the doubleword that holds the check value and the two fixed bytes. The bench can therefore break the checksum by host writes and then restore it. It also exercises a load with an idle gap and host traffic arriving in the middle of the load.

// File: rtl/asm_pkg.sv
package asm_pkg;

   typedef enum logic [1:0] {
      SZ_BAD   = 2'd0,
      SZ_BYTE  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   // Size is taken from a lane mask that is contiguous from lane 0.
   function automatic acc_size_e mask_to_size(input logic [3:0] be);
      case (be)
         4'b0001: mask_to_size = SZ_BYTE;
         4'b0011: mask_to_size = SZ_WORD;
         4'b1111: mask_to_size = SZ_DWORD;
         default: mask_to_size = SZ_BAD;
      endcase
   endfunction

endpackage

// File: rtl/asm_load_seq.sv
module asm_load_seq #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   output logic              ld_we,
   output logic [ADDR_W-1:0] ld_idx,
   output logic              busy
);
   localparam int NBYTES = 1 << ADDR_W;
   localparam int PW     = ADDR_W + 1;

   logic [PW-1:0] ptr_q;

   assign busy   = (ptr_q != PW'(NBYTES));
   assign ld_we  = ld_valid && busy;
   assign ld_idx = ptr_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (ld_we) ptr_q <= ptr_q + PW'(1);
   end
endmodule

// File: rtl/asm_access_chk.sv
module asm_access_chk
   import asm_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_off,
   input  logic [3:0]        host_be,
   input  logic              dw_mode,
   input  logic              wr_en_cfg,
   input  logic              busy,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic              err_now
);
   acc_size_e size;
   logic      active, dw_legal, rd_legal, wr_legal, both;

   always_comb begin
      size     = mask_to_size(host_be);
      active   = !busy && (host_rd || host_wr);
      both     = host_rd && host_wr;
      dw_legal = (size == SZ_DWORD) && (host_off[1:0] == 2'b00);
      if (dw_mode) begin
         rd_legal = dw_legal;
         wr_legal = dw_legal;
      end else begin
         rd_legal = (size == SZ_BYTE) || ((size == SZ_WORD) && !host_off[0]);
         wr_legal = (size == SZ_WORD) && !host_off[0];
      end
      err_now = active && (both || (host_rd && !rd_legal) || (host_wr && !wr_legal));
      rd_ok   = active && host_rd && !host_wr && rd_legal;
      wr_ok   = active && host_wr && !host_rd && wr_legal && wr_en_cfg;
   end
endmodule

// File: rtl/asm_byte_array.sv
module asm_byte_array #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_we,
   input  logic [ADDR_W-1:0]        ld_idx,
   input  logic [7:0]               ld_byte,
   input  logic                     wr_ok,
   input  logic                     rd_ok,
   input  logic [ADDR_W-1:0]        host_off,
   input  logic [DATA_W/8-1:0]      host_be,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [DATA_W-1:0]        rd_data,
   output logic [(8<<ADDR_W)-1:0]   mem_flat
);
   localparam int NBYTES = 1 << ADDR_W;
   localparam int LANES  = DATA_W / 8;
   localparam int IW     = ADDR_W + 1;

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic       hit;
      logic [7:0] hdat;
      logic [7:0] q;

      always_comb begin
         hit  = 1'b0;
         hdat = 8'h00;
         for (int k = 0; k < LANES; k++) begin
            if (wr_ok && host_be[k] && (({1'b0, host_off} + IW'(k)) == IW'(i))) begin
               hit  = 1'b1;
               hdat = host_wdata[8*k +: 8];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                           q <= 8'h00;
         else if (ld_we && (ld_idx == ADDR_W'(i))) q <= ld_byte;
         else if (hit)                         q <= hdat;
      end

      assign mem_flat[8*i +: 8] = q;
   end

   logic [DATA_W-1:0] rd_next;
   logic [ADDR_W-1:0] ix;

   always_comb begin
      rd_next = '0;
      ix      = '0;
      for (int k = 0; k < LANES; k++) begin
         ix = host_off + ADDR_W'(k);
         if (rd_ok && host_be[k]) rd_next[8*k +: 8] = mem_flat[8*ix +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_next;
   end
endmodule

// File: rtl/asm_cksum.sv
module asm_cksum #(
   parameter int ADDR_W = 4,
   parameter int CK_POS = 12,
   parameter bit CK_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [(8<<ADDR_W)-1:0] mem_flat,
   input  logic                   busy,
   output logic                   checksum_ok
);
   localparam int NBYTES = 1 << ADDR_W;

   logic [15:0] sum;
   logic [15:0] stored;
   logic        match;

   always_comb begin
      sum = 16'h0000;
      for (int i = 1; i < NBYTES; i++) begin
         if (i != CK_POS && i != CK_POS + 1) sum = sum + 16'(mem_flat[8*i +: 8]);
      end
      stored = {mem_flat[8*(CK_POS+1) +: 8], mem_flat[8*CK_POS +: 8]};
      match  = !busy && (sum == stored);
   end

   if (CK_REG) begin : g_reg
      logic ok_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ok_q <= 1'b0;
         else        ok_q <= match;
      end
      assign checksum_ok = ok_q;
   end else begin : g_comb
      assign checksum_ok = match;
   end
endmodule

// File: rtl/addr_shadow_mem.sv
module addr_shadow_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CK_POS = 12,
   parameter bit CK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [7:0]        ld_byte,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_off,
   input  logic [3:0]        host_be,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              dw_mode,
   input  logic              wr_en_cfg,
   output logic [DATA_W-1:0] rd_data,
   output logic              access_err,
   output logic              busy,
   output logic              checksum_ok
);
   localparam int NBYTES = 1 << ADDR_W;

   if (DATA_W != 32) begin : g_bad_dw
      $error("addr_shadow_mem: DATA_W must be 32");
   end
   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_aw
      $error("addr_shadow_mem: ADDR_W must lie in 2..8");
   end
   if (CK_POS < 1 || CK_POS + 1 >= NBYTES) begin : g_bad_ck
      $error("addr_shadow_mem: CK_POS out of range");
   end

   logic              ld_we;
   logic [ADDR_W-1:0] ld_idx;
   logic              rd_ok, wr_ok, err_now;
   logic [8*NBYTES-1:0] arr_flat;

   asm_load_seq #(.ADDR_W(ADDR_W)) u_load (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
      .ld_we(ld_we), .ld_idx(ld_idx), .busy(busy)
   );

   asm_access_chk #(.ADDR_W(ADDR_W)) u_chk (
      .host_rd(host_rd), .host_wr(host_wr), .host_off(host_off),
      .host_be(host_be), .dw_mode(dw_mode), .wr_en_cfg(wr_en_cfg),
      .busy(busy), .rd_ok(rd_ok), .wr_ok(wr_ok), .err_now(err_now)
   );

   asm_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx),
      .ld_byte(ld_byte), .wr_ok(wr_ok), .rd_ok(rd_ok),
      .host_off(host_off), .host_be(host_be), .host_wdata(host_wdata),
      .rd_data(rd_data), .mem_flat(arr_flat)
   );

   asm_cksum #(.ADDR_W(ADDR_W), .CK_POS(CK_POS), .CK_REG(CK_REG)) u_ck (
      .clk(clk), .rst_n(rst_n), .mem_flat(arr_flat), .busy(busy),
      .checksum_ok(checksum_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) access_err <= 1'b0;
      else        access_err <= err_now;
   end
endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   host_rd,
   input logic                   host_wr,
   input logic [3:0]             host_be,
   input logic                   dw_mode,
   input logic                   wr_en_cfg,
   input logic                   busy,
   input logic                   access_err,
   input logic [DATA_W-1:0]      rd_data,
   input logic                   checksum_ok,
   input logic [(8<<ADDR_W)-1:0] arr_flat
);
   assert_busy_stays_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

   assert_busy_ignores_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (host_rd || host_wr)) |=> (!access_err && rd_data == '0));

   assert_dw_small_read_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_mode && host_rd && !busy && host_be != 4'hF) |=> access_err);

   assert_disabled_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !wr_en_cfg && !busy) |=> $stable(arr_flat));

   assert_err_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      access_err |-> $past(host_rd || host_wr));

   assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      access_err |-> (rd_data == '0));

   assert_ck_needs_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      checksum_ok |-> !busy);
endmodule

bind addr_shadow_mem asm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_asm_checker (
   .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
   .host_be(host_be), .dw_mode(dw_mode), .wr_en_cfg(wr_en_cfg),
   .busy(busy), .access_err(access_err), .rd_data(rd_data),
   .checksum_ok(checksum_ok), .arr_flat(arr_flat)
);

// File: tb/sim_addr_shadow_mem.sv
`timescale 1ns/100ps
module sim_addr_shadow_mem;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [7:0]  ld_byte = 8'h00;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [3:0]  host_off = 4'h0, host_be = 4'h0;
   logic [31:0] host_wdata = 32'h0;
   logic        dw_mode = 1'b0, wr_en_cfg = 1'b0;
   logic [31:0] rd_data;
   logic        access_err, busy, checksum_ok;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   addr_shadow_mem u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
      .host_rd(host_rd), .host_wr(host_wr), .host_off(host_off),
      .host_be(host_be), .host_wdata(host_wdata), .dw_mode(dw_mode),
      .wr_en_cfg(wr_en_cfg), .rd_data(rd_data), .access_err(access_err),
      .busy(busy), .checksum_ok(checksum_ok)
   );

   localparam logic [7:0] IMG [16] = '{
      8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h00,
      8'h00, 8'h00, 8'h00, 8'h00, 8'hAD, 8'h01, 8'h57, 8'h57 };

   // op(2) dw cfg off(4) be(4) wdata(32) exp_data(32) exp_err ; op 1=rd 2=wr 3=both
   localparam int NV = 21;
   localparam logic [76:0] VECS [NV] = '{
      {2'd1,1'b0,1'b0,4'h5,4'h1,32'h0,32'h00000055,1'b0},
      {2'd1,1'b0,1'b0,4'hF,4'h1,32'h0,32'h00000057,1'b0},
      {2'd1,1'b0,1'b0,4'h2,4'h3,32'h0,32'h00003322,1'b0},
      {2'd1,1'b0,1'b0,4'h3,4'h3,32'h0,32'h00000000,1'b1},
      {2'd1,1'b0,1'b0,4'h0,4'hF,32'h0,32'h00000000,1'b1},
      {2'd1,1'b1,1'b0,4'h0,4'hF,32'h0,32'h33221102,1'b0},
      {2'd1,1'b1,1'b0,4'hC,4'hF,32'h0,32'h575701AD,1'b0},
      {2'd1,1'b1,1'b0,4'h4,4'h3,32'h0,32'h00000000,1'b1},
      {2'd1,1'b1,1'b0,4'h2,4'hF,32'h0,32'h00000000,1'b1},
      {2'd2,1'b0,1'b1,4'h6,4'h3,32'h0000BEEF,32'h0,1'b0},
      {2'd1,1'b0,1'b0,4'h6,4'h3,32'h0,32'h0000BEEF,1'b0},
      {2'd2,1'b1,1'b0,4'h8,4'hF,32'h12345678,32'h0,1'b0},
      {2'd1,1'b1,1'b0,4'h8,4'hF,32'h0,32'h00000000,1'b0},
      {2'd2,1'b1,1'b1,4'h8,4'hF,32'hA1B2C3D4,32'h0,1'b0},
      {2'd1,1'b1,1'b0,4'h8,4'hF,32'h0,32'hA1B2C3D4,1'b0},
      {2'd2,1'b0,1'b1,4'h1,4'h3,32'h0000FFFF,32'h0,1'b1},
      {2'd2,1'b0,1'b1,4'h0,4'h1,32'h000000FF,32'h0,1'b1},
      {2'd2,1'b1,1'b1,4'h4,4'h3,32'h0000FFFF,32'h0,1'b1},
      {2'd3,1'b0,1'b1,4'h0,4'h3,32'h0000FFFF,32'h0,1'b1},
      {2'd1,1'b0,1'b0,4'h0,4'h3,32'h0,32'h00001102,1'b0},
      {2'd1,1'b1,1'b0,4'h4,4'hF,32'h0,32'hBEEF5544,1'b0} };

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 2, 4: tag_of = "R5";
         5, 6, 7, 8: tag_of = "R6";
         11, 12:     tag_of = "R8";
         9, 10, 13, 14, 20: tag_of = "R7";
         default:    tag_of = "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [31:0] got_d;
   logic        got_e;

   // Drive at one falling edge, sample the registered result at the next.
   task automatic access(input logic [1:0] op, input logic dw, input logic cfg,
                         input logic [3:0] off, input logic [3:0] be, input logic [31:0] wd);
      @(negedge clk);
      host_rd = op[0]; host_wr = op[1]; dw_mode = dw; wr_en_cfg = cfg;
      host_off = off; host_be = be; host_wdata = wd;
      @(negedge clk);
      got_d = rd_data; got_e = access_err;
      host_rd = 1'b0; host_wr = 1'b0; wr_en_cfg = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {31'd0, busy}, 32'd1);
      check("R1", rd_data, 32'd0);
      check("R1", {31'd0, access_err}, 32'd0);
      check("R1", {31'd0, checksum_ok}, 32'd0);

      // R2 first three bytes, then a gap carrying host traffic
      for (int b = 0; b < 3; b++) begin
         ld_valid = 1'b1; ld_byte = IMG[b];
         @(negedge clk);
      end
      ld_valid = 1'b0;
      access(2'd2, 1'b0, 1'b1, 4'h0, 4'h3, 32'h0000FFFF);
      check("R3", {31'd0, got_e}, 32'd0);
      access(2'd1, 1'b0, 1'b0, 4'h0, 4'h3, 32'h0);
      check("R3", got_d, 32'd0);
      check("R3", {31'd0, got_e}, 32'd0);
      check("R2", {31'd0, busy}, 32'd1);

      for (int b = 3; b < 16; b++) begin
         ld_valid = 1'b1; ld_byte = IMG[b];
         @(negedge clk);
      end
      ld_valid = 1'b0;
      check("R2", {31'd0, busy}, 32'd0);
      check("R10", {31'd0, checksum_ok}, 32'd1);

      // R2 extra load byte after completion is ignored
      ld_valid = 1'b1; ld_byte = 8'hFF;
      @(negedge clk);
      ld_valid = 1'b0;
      access(2'd1, 1'b0, 1'b0, 4'h0, 4'h3, 32'h0);
      check("R2", got_d, 32'h00001102);
      check("R3", got_d, 32'h00001102);
      check("R4", got_d, 32'h00001102);

      for (int i = 0; i < NV; i++) begin
         logic [76:0] v;
         v = VECS[i];
         access(v[76:75], v[74], v[73], v[72:69], v[68:65], v[64:33]);
         check(tag_of(i), got_d, v[32:1]);
         check(tag_of(i), {31'd0, got_e}, {31'd0, v[0]});
      end

      // R9 error lasts one cycle
      access(2'd1, 1'b1, 1'b0, 4'h0, 4'h1, 32'h0);
      check("R9", {31'd0, got_e}, 32'd1);
      @(negedge clk);
      check("R9", {31'd0, access_err}, 32'd0);
      check("R4", rd_data, 32'd0);

      // R10 broken by earlier writes, then restored
      check("R10", {31'd0, checksum_ok}, 32'd0);
      access(2'd2, 1'b1, 1'b1, 4'hC, 4'hF, 32'h57570644);
      check("R10", {31'd0, checksum_ok}, 32'd1);
      access(2'd2, 1'b0, 1'b1, 4'h0, 4'h3, 32'h000011AA);
      check("R10", {31'd0, checksum_ok}, 32'd1);
      access(2'd1, 1'b0, 1'b0, 4'h0, 4'h1, 32'h0);
      check("R7", got_d, 32'h000000AA);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule